// File: doc/BRIEF.md
# Dual-Core Idle State Coordinator

This block sits between two processor cores and the platform's power management. Each core asks for an idle level of its own, from fully active to the deepest sleep. The coordinator merges the two requests into one package level, the shallower of the two, and shows the platform that single level as if it came from one processor. Software can therefore manage each core on its own, while the shared resources follow the common limit of both.

The block gates each core's clock spine as soon as that core asks for any idle level. It gates the shared-resource spine only when both cores are idle and no shared traffic is in flight. A keep-alive control can hold the shared spine running, so that snoops and interrupt messages are still served while both cores are halted. When both cores ask for level 2 or deeper, a sequencer raises an entry request to the platform. It waits while the platform holds its stop sideband. When that sideband is released, or a break event arrives before the platform has acted, it first restores the shared clock for one cycle and then sends a one-cycle wake pulse to each core that is still idle.

Top module: `idle_coord`

## Requirements
- R1: Levels are 3-bit codes: 0 active, 1 halt, 2, 3 and 4 progressively deeper; request codes 5 to 7 count as 4. When no core requests 0, the package level becomes the minimum of the clamped requests at the second clock edge after the requests change, provided they hold steady in between. Otherwise it keeps its old value.
- R2: If any core requests 0, the package level is 0 after the next clock edge.
- R3: The clock enable of core i (bit i of the enable vector; core i's request occupies bits 3i+2..3i) is high after the next edge exactly when that core requested 0. All enables are high out of reset.
- R4: The shared clock enable is low only when the package level is nonzero, every shared busy flag is low, keep-alive is low and the sequencer is neither restoring nor waking.
- R5: Any single shared busy flag that is high keeps the shared clock enabled.
- R6: Keep-alive high keeps the shared clock enabled whatever the other inputs are.
- R7: One edge after the package level reaches 2 or deeper, the platform entry request rises. It stays high until the platform releases its stop input or the entry is abandoned.
- R8: If the package level drops below 2 before the platform raises stop, the entry request falls on the next edge, and a later stop input has no effect.
- R9: On the edge where stop is seen released, the sequencer enters a restore cycle: shared clock on, entry request low, no wake. On the following edge it enters a wake cycle that pulses the wake bit of each core whose registered request is nonzero, then returns to run.
- R10: A break event seen while the entry request is pending (before stop) starts the same restore-then-wake sequence. A break event with no entry in progress has no effect.
- R11: While reset is held, the package level is 0, both core clock enables are high, and the entry request and wake outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_i | input | NCORE*3 | Requested idle level per core, core i in bits 3i+2..3i |
| shared_busy_i | input | BUSY_W | Shared-resource activity flags (bus, cache) |
| keep_shared_i | input | 1 | Keep the shared clock running |
| plat_stop_i | input | 1 | Platform stop/sleep sideband, high while held asleep |
| break_i | input | 1 | Break event from the platform |
| core_clk_en_o | output | NCORE | Per-core clock spine enable |
| shared_clk_en_o | output | 1 | Shared-resource clock spine enable |
| pkg_state_o | output | 3 | Coordinated package idle level |
| plat_entry_req_o | output | 1 | Entry request to the platform for the package level |
| core_wake_o | output | NCORE | One-cycle wake pulse per core |

## Verification
The bench builds the block with two cores and two shared busy flags. It sweeps all 64 pairs of request codes, including the clamped ones, and checks the merged level, the fast return to 0, the per-core enables and the entry request after each pair. With two busy flags, all combinations of busy and keep-alive fit in a short loop. Directed sequences then cover the full stop/release exit, a wake mask that changes during restore, an abandoned entry with a late stop, and break events with and without a pending entry.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;

    localparam int STATE_W = 3;
    localparam logic [STATE_W-1:0] LVL_ACTIVE = 3'd0;
    localparam logic [STATE_W-1:0] LVL_DEEPEST = 3'd4;
    localparam logic [STATE_W-1:0] LVL_ENTRY_MIN = 3'd2;

    typedef enum logic [2:0] {
        SEQ_RUN,
        SEQ_ENTRY,
        SEQ_SLEEP,
        SEQ_RESTORE,
        SEQ_WAKE
    } seq_e;

    typedef struct packed {
        logic entry_req;
        logic force_shared;
    } seq_ctl_t;

    function automatic logic [STATE_W-1:0] clamp_req(input logic [STATE_W-1:0] r);
        return (r > LVL_DEEPEST) ? LVL_DEEPEST : r;
    endfunction

    function automatic logic [STATE_W-1:0] shallower(input logic [STATE_W-1:0] a,
                                                     input logic [STATE_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/idle_req_merge.sv
module idle_req_merge
    import idle_coord_pkg::*;
#(
    parameter int NCORE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORE*STATE_W-1:0] req_i,
    output logic [NCORE*STATE_W-1:0] req_q_o,
    output logic [STATE_W-1:0]       pkg_o
);

    logic [NCORE*STATE_W-1:0] req_q;
    logic [STATE_W-1:0]       pkg_q;
    logic [STATE_W-1:0]       floor_d;
    logic                     any_active;
    logic                     steady;

    always_comb begin
        floor_d    = LVL_DEEPEST;
        any_active = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            floor_d = shallower(floor_d, clamp_req(req_i[i*STATE_W +: STATE_W]));
            if (req_i[i*STATE_W +: STATE_W] == LVL_ACTIVE) begin
                any_active = 1'b1;
            end
        end
        steady = (req_i == req_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pkg_q <= LVL_ACTIVE;
        end else begin
            req_q <= req_i;
            if (any_active) begin
                pkg_q <= LVL_ACTIVE;
            end else if (steady) begin
                pkg_q <= floor_d;
            end
        end
    end

    assign req_q_o = req_q;
    assign pkg_o   = pkg_q;

endmodule

// File: rtl/idle_spine_gate.sv
module idle_spine_gate
    import idle_coord_pkg::*;
#(
    parameter int NCORE  = 2,
    parameter int BUSY_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORE*STATE_W-1:0] req_i,
    input  logic [STATE_W-1:0]       pkg_i,
    input  logic [BUSY_W-1:0]        busy_i,
    input  logic                     keep_i,
    input  logic                     force_on_i,
    output logic [NCORE-1:0]         core_en_o,
    output logic                     shared_en_o
);

    for (genvar g = 0; g < NCORE; g++) begin : g_core_spine
        logic en_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q <= 1'b1;
            end else begin
                en_q <= (req_i[g*STATE_W +: STATE_W] == LVL_ACTIVE);
            end
        end
        assign core_en_o[g] = en_q;
    end

    logic all_idle;
    logic traffic_quiet;

    assign all_idle      = (pkg_i != LVL_ACTIVE);
    assign traffic_quiet = (busy_i == '0);
    assign shared_en_o   = !(all_idle && traffic_quiet && !keep_i && !force_on_i);

endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import idle_coord_pkg::*;
#(
    parameter int NCORE = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [STATE_W-1:0]       pkg_i,
    input  logic [NCORE*STATE_W-1:0] req_q_i,
    input  logic                     stop_i,
    input  logic                     break_i,
    output seq_ctl_t                 ctl_o,
    output logic [NCORE-1:0]         wake_o
);

    seq_e state_q;
    seq_e state_d;
    logic deep_enough;

    assign deep_enough = (pkg_i >= LVL_ENTRY_MIN);

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_RUN: begin
                if (deep_enough) state_d = SEQ_ENTRY;
            end
            SEQ_ENTRY: begin
                if (break_i)           state_d = SEQ_RESTORE;
                else if (stop_i)       state_d = SEQ_SLEEP;
                else if (!deep_enough) state_d = SEQ_RUN;
            end
            SEQ_SLEEP: begin
                if (!stop_i) state_d = SEQ_RESTORE;
            end
            SEQ_RESTORE: state_d = SEQ_WAKE;
            SEQ_WAKE:    state_d = SEQ_RUN;
            default:     state_d = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctl_o.entry_req    = (state_q == SEQ_ENTRY) || (state_q == SEQ_SLEEP);
        ctl_o.force_shared = (state_q == SEQ_RESTORE) || (state_q == SEQ_WAKE);
        for (int i = 0; i < NCORE; i++) begin
            wake_o[i] = (state_q == SEQ_WAKE) &&
                        (req_q_i[i*STATE_W +: STATE_W] != LVL_ACTIVE);
        end
    end

endmodule

// File: rtl/idle_coord.sv
module idle_coord
    import idle_coord_pkg::*;
#(
    parameter int NCORE  = 2,
    parameter int BUSY_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORE*STATE_W-1:0] core_req_i,
    input  logic [BUSY_W-1:0]        shared_busy_i,
    input  logic                     keep_shared_i,
    input  logic                     plat_stop_i,
    input  logic                     break_i,
    output logic [NCORE-1:0]         core_clk_en_o,
    output logic                     shared_clk_en_o,
    output logic [STATE_W-1:0]       pkg_state_o,
    output logic                     plat_entry_req_o,
    output logic [NCORE-1:0]         core_wake_o
);

    logic [NCORE*STATE_W-1:0] req_q;
    logic [STATE_W-1:0]       pkg_lvl;
    seq_ctl_t                 seq_ctl;

    idle_req_merge #(.NCORE(NCORE)) u_merge (
        .clk     (clk),
        .rst     (rst),
        .req_i   (core_req_i),
        .req_q_o (req_q),
        .pkg_o   (pkg_lvl)
    );

    idle_seq_fsm #(.NCORE(NCORE)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pkg_i   (pkg_lvl),
        .req_q_i (req_q),
        .stop_i  (plat_stop_i),
        .break_i (break_i),
        .ctl_o   (seq_ctl),
        .wake_o  (core_wake_o)
    );

    idle_spine_gate #(.NCORE(NCORE), .BUSY_W(BUSY_W)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .req_i       (core_req_i),
        .pkg_i       (pkg_lvl),
        .busy_i      (shared_busy_i),
        .keep_i      (keep_shared_i),
        .force_on_i  (seq_ctl.force_shared),
        .core_en_o   (core_clk_en_o),
        .shared_en_o (shared_clk_en_o)
    );

    assign pkg_state_o      = pkg_lvl;
    assign plat_entry_req_o = seq_ctl.entry_req;

endmodule

// File: rtl/idle_coord_chk.sv
module idle_coord_chk
    import idle_coord_pkg::*;
#(
    parameter int NCORE  = 2,
    parameter int BUSY_W = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NCORE*STATE_W-1:0] core_req_i,
    input logic [BUSY_W-1:0]        shared_busy_i,
    input logic                     keep_shared_i,
    input logic                     plat_stop_i,
    input logic                     break_i,
    input logic [NCORE-1:0]         core_clk_en_o,
    input logic                     shared_clk_en_o,
    input logic [STATE_W-1:0]       pkg_state_o,
    input logic                     plat_entry_req_o,
    input logic [NCORE-1:0]         core_wake_o
);

    logic any_c0;
    always_comb begin
        any_c0 = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            if (core_req_i[i*STATE_W +: STATE_W] == LVL_ACTIVE) any_c0 = 1'b1;
        end
    end

    // R1
    pkg_range_chk: assert property (@(posedge clk) disable iff (rst)
        pkg_state_o <= LVL_DEEPEST);

    // R1
    pkg_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pkg_state_o) && pkg_state_o != LVL_ACTIVE)
        |-> ($past(core_req_i) == $past(core_req_i, 2)));

    // R2
    fast_active_chk: assert property (@(posedge clk) disable iff (rst)
        any_c0 |=> (pkg_state_o == LVL_ACTIVE));

    for (genvar g = 0; g < NCORE; g++) begin : g_core_chk
        // R3
        core_ungate_chk: assert property (@(posedge clk) disable iff (rst)
            (core_req_i[g*STATE_W +: STATE_W] == LVL_ACTIVE) |=> core_clk_en_o[g]);
        // R3
        core_gate_chk: assert property (@(posedge clk) disable iff (rst)
            (core_req_i[g*STATE_W +: STATE_W] != LVL_ACTIVE) |=> !core_clk_en_o[g]);
    end

    // R4
    shared_gate_cond_chk: assert property (@(posedge clk) disable iff (rst)
        !shared_clk_en_o |-> (shared_busy_i == '0 && pkg_state_o != LVL_ACTIVE));

    // R6
    keep_alive_chk: assert property (@(posedge clk) disable iff (rst)
        keep_shared_i |-> shared_clk_en_o);

    // R7
    entry_depth_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(plat_entry_req_o) |-> ($past(pkg_state_o) >= LVL_ENTRY_MIN));

    // R9
    wake_after_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (core_wake_o != '0) |-> (shared_clk_en_o && !plat_entry_req_o));

    // R9
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (core_wake_o != '0) |=> (core_wake_o == '0));

endmodule

bind idle_coord idle_coord_chk #(.NCORE(NCORE), .BUSY_W(BUSY_W)) u_chk (.*);

// File: tb/idle_coord_bench.sv
module idle_coord_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCORE      = 2;
    localparam int BUSY_W     = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic [5:0]       core_req;
    logic [1:0]       busy;
    logic             keep;
    logic             stop;
    logic             brk;
    logic [1:0]       core_en;
    logic             shared_en;
    logic [2:0]       pkg;
    logic             entry;
    logic [1:0]       wake;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_coord #(.NCORE(NCORE), .BUSY_W(BUSY_W)) u_idle_coord (
        .clk              (clk),
        .rst              (rst),
        .core_req_i       (core_req),
        .shared_busy_i    (busy),
        .keep_shared_i    (keep),
        .plat_stop_i      (stop),
        .break_i          (brk),
        .core_clk_en_o    (core_en),
        .shared_clk_en_o  (shared_en),
        .pkg_state_o      (pkg),
        .plat_entry_req_o (entry),
        .core_wake_o      (wake)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        return (v > 4) ? 4 : v;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_req(input int c0, input int c1);
        core_req = {3'(c1), 3'(c0)};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; core_req = '0; busy = '0; keep = 1'b0; stop = 1'b0; brk = 1'b0;
        set_req(4, 3);
        repeat (3) tick();
        // R11 reset state
        chk(pkg == 3'd0, "R11 pkg", pkg, 0);
        chk(core_en == 2'b11, "R11 core_en", core_en, 3);
        chk(entry == 1'b0, "R11 entry", entry, 0);
        chk(wake == 2'b00, "R11 wake", wake, 0);
        set_req(0, 0);
        rst = 1'b0;
        repeat (3) tick();

        // Sweep all request pairs: R1 R2 R3 R4 R7 R8
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                int m;
                m = (clampv(a) < clampv(b)) ? clampv(a) : clampv(b);
                set_req(a, b);
                tick();
                chk(core_en == {b == 0, a == 0}, "R3 core enables", core_en, {b == 0, a == 0});
                if (m == 0) chk(pkg == 3'd0, "R2 fast active", pkg, 0);
                tick();
                chk(pkg == 3'(m), "R1 merged level", pkg, m);
                chk(shared_en == (m == 0), "R4 shared gate", shared_en, m == 0);
                tick();
                chk(entry == (m >= 2), "R7 entry request", entry, m >= 2);
            end
        end
        set_req(0, 0);
        repeat (3) tick();

        // R5 R6 busy/keep combinations with both cores deep
        set_req(3, 3);
        repeat (3) tick();
        for (int bs = 0; bs < 4; bs++) begin
            for (int kp = 0; kp < 2; kp++) begin
                busy = 2'(bs);
                keep = 1'(kp);
                #1;
                if (kp == 1) chk(shared_en == 1'b1, "R6 keep alive", shared_en, 1);
                else chk(shared_en == (bs != 0), "R5 busy hold", shared_en, bs != 0);
            end
        end
        busy = '0; keep = 1'b0;

        // R9 full entry, sleep, release
        set_req(3, 4);
        repeat (3) tick();
        chk(entry == 1'b1, "R7 entry raised", entry, 1);
        chk(pkg == 3'd3, "R1 level 3", pkg, 3);
        stop = 1'b1;
        tick();
        chk(entry == 1'b1, "R7 entry held in sleep", entry, 1);
        chk(shared_en == 1'b0, "R4 shared gated in sleep", shared_en, 0);
        tick();
        stop = 1'b0;
        tick();
        chk(shared_en == 1'b1, "R9 restore shared on", shared_en, 1);
        chk(entry == 1'b0, "R9 restore entry low", entry, 0);
        chk(wake == 2'b00, "R9 restore no wake", wake, 0);
        tick();
        chk(wake == 2'b11, "R9 wake both", wake, 3);
        chk(shared_en == 1'b1, "R9 wake shared on", shared_en, 1);
        tick();
        chk(wake == 2'b00, "R9 wake pulse ends", wake, 0);
        set_req(0, 0);
        repeat (4) tick();

        // R9 wake mask follows registered requests
        set_req(2, 2);
        repeat (3) tick();
        stop = 1'b1;
        tick();
        stop = 1'b0;
        tick();
        set_req(2, 0);
        tick();
        chk(wake == 2'b01, "R9 wake mask core0 only", wake, 1);
        set_req(0, 0);
        repeat (4) tick();

        // R8 abandoned entry, late stop ignored
        set_req(2, 2);
        repeat (3) tick();
        chk(entry == 1'b1, "R8 entry before drop", entry, 1);
        set_req(1, 2);
        repeat (3) tick();
        chk(entry == 1'b0, "R8 entry withdrawn", entry, 0);
        chk(pkg == 3'd1, "R8 level 1", pkg, 1);
        stop = 1'b1;
        tick();
        chk(entry == 1'b0, "R8 late stop no entry", entry, 0);
        stop = 1'b0;
        tick();
        chk(wake == 2'b00, "R8 late stop no wake", wake, 0);

        // R10 break during pending entry
        set_req(4, 4);
        repeat (3) tick();
        chk(entry == 1'b1, "R10 entry pending", entry, 1);
        brk = 1'b1;
        tick();
        brk = 1'b0;
        chk(entry == 1'b0, "R10 restore entry low", entry, 0);
        chk(shared_en == 1'b1, "R10 restore shared on", shared_en, 1);
        tick();
        chk(wake == 2'b11, "R10 wake after break", wake, 3);
        set_req(1, 1);
        repeat (4) tick();

        // R10 break without entry ignored
        brk = 1'b1;
        tick();
        brk = 1'b0;
        chk(entry == 1'b0, "R10 idle break entry", entry, 0);
        chk(shared_en == 1'b0, "R10 idle break shared", shared_en, 0);
        tick();
        chk(wake == 2'b00, "R10 idle break wake", wake, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule